// File: doc/BRIEF.md
# Circular Register Stack with Top Pointer

This block holds eight 80-bit data entries arranged as a ring-shaped stack. Entries are not named by fixed register numbers. They are located relative to a 3-bit top pointer, and that pointer is kept inside a 16-bit status word.

A push first moves the pointer down by one and then stores the incoming value in the new top entry. A pop presents the current top entry and moves the pointer up by one. Between those two operations, any entry can be read or written at a distance i above the top, written ST(i), which maps to physical entry (top + i) mod 8.

The execution unit can raise and drop a busy flag. Arithmetic results can load four condition-code bits. The whole status word is visible combinationally at every cycle, whether or not the busy flag is set.

Top module: `circ_reg_stack`

## Requirements
- R1: While reset is asserted and after it is released, the status word reads 16'h0000, which means the top pointer is 0, busy is 0 and all condition codes are 0.
- R2: When `push_i` is high at a clock edge, the top pointer becomes (top - 1) mod 8. `push_data_i` is stored in the entry the new pointer names, and `pop_data_o` shows that value from the next cycle.
- R3: `pop_data_o` always shows the entry at the current top pointer. When `pop_i` is high, `push_i` is low and a clock edge occurs, the pointer becomes (top + 1) mod 8 and no entry changes.
- R4: `rel_rdata_o` shows physical entry (top + `rel_idx_i`) mod 8, with no added latency.
- R5: When `rel_we_i` is high and `push_i` is low at a clock edge, `rel_wdata_i` is stored in entry (top + `rel_idx_i`) mod 8. The top used is the value before any pop in the same cycle.
- R6: When `push_i` and `rel_we_i` are both high in the same cycle, the push is performed and the top-relative write is dropped.
- R7: When `push_i` and `pop_i` are both high in the same cycle, the push is performed and the pop is ignored.
- R8: Status layout: bit 15 is busy, bit 14 is C3, bits 13:11 are the top pointer, bits 10, 9 and 8 are C2, C1 and C0, and bits 7:0 are zero.
- R9: `busy_set_i` sets the busy flag and `busy_clr_i` clears it. Set wins if both are high. The busy flag does not stall or alter any stack command or status read.
- R10: When `cc_we_i` is high, the condition codes load from `cc_i`, with bit 3 to C3, bit 2 to C2, bit 1 to C1 and bit 0 to C0. Otherwise they hold.
- R11: The pointer wraps: a push at top 0 gives top 7, and a pop at top 7 gives top 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push command |
| push_data_i | input | 80 | Value to push |
| pop_i | input | 1 | Pop command |
| pop_data_o | output | 80 | Entry at the current top |
| rel_idx_i | input | 3 | Distance i for ST(i) |
| rel_we_i | input | 1 | Write ST(i) |
| rel_wdata_i | input | 80 | Value for ST(i) write |
| rel_rdata_o | output | 80 | Value of ST(i) |
| busy_set_i | input | 1 | Raise busy flag |
| busy_clr_i | input | 1 | Drop busy flag |
| cc_we_i | input | 1 | Load condition codes |
| cc_i | input | 4 | New condition codes {C3,C2,C1,C0} |
| status_o | output | 16 | Status word |

## Verification
Ten consecutive pushes of distinct patterns carry the pointer past 0, so a wrap error shows apart from a plain decrement error. At each of the eight pointer positions that the following pops pass through, all eight ST(i) distances are read. This separates a wrong modular index from a wrong data path.

A sweep of ST(i) writes followed by a full read-back tells a misplaced write from a missing one. Cycles that combine a push with a write, and a push with a pop, expose which command the arbitration lets through. A walk over all sixteen condition-code values, together with the busy set/clear combinations, checks every status bit position against its computed value.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int TOP_W   = 3;
    localparam int DEPTH   = 1 << TOP_W;
    localparam int STAT_W  = 16;

    typedef struct packed {
        logic             busy;
        logic [3:0]       cc;     // {C3,C2,C1,C0}
        logic [TOP_W-1:0] top;
    } ptr_state_t;

    function automatic logic [STAT_W-1:0] pack_status(input ptr_state_t s);
        logic [STAT_W-1:0] w;
        w        = '0;
        w[15]    = s.busy;
        w[14]    = s.cc[3];
        w[13:11] = s.top;
        w[10]    = s.cc[2];
        w[9]     = s.cc[1];
        w[8]     = s.cc[0];
        return w;
    endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic              pop_en,
    input  logic              busy_set,
    input  logic              busy_clr,
    input  logic              cc_we,
    input  logic [3:0]        cc_in,
    output logic [TOP_W-1:0]  top_o,
    output logic [STAT_W-1:0] status_o
);
    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_en)
            st_d.top = st_q.top - TOP_W'(1);
        else if (pop_en)
            st_d.top = st_q.top + TOP_W'(1);
        if (busy_set)
            st_d.busy = 1'b1;
        else if (busy_clr)
            st_d.busy = 1'b0;
        if (cc_we)
            st_d.cc = cc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign top_o    = st_q.top;
    assign status_o = pack_status(st_q);

    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> top_o == $past(top_o) - TOP_W'(1));
    p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en) |=> top_o == $past(top_o) + TOP_W'(1));
    p_top_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_en && !push_en) |=> $stable(top_o));
    p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_set |=> status_o[15]);
    p_cc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |=> ({status_o[14], status_o[10:8]} == $past({status_o[14], status_o[10:8]})));
endmodule

// File: rtl/stk_array.sv
module stk_array
    import stk_pkg::*;
#(
    parameter int WIDTH = 80
) (
    input  logic             clk,
    input  logic             we,
    input  logic [TOP_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [TOP_W-1:0] raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [TOP_W-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [WIDTH-1:0] ent_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (we && waddr == TOP_W'(g))
                ent_d[g] = wdata;
        end
        always_ff @(posedge clk) begin
            ent_q[g] <= ent_d[g];
        end
    end

    assign rdata_a = ent_q[raddr_a];
    assign rdata_b = ent_q[raddr_b];
endmodule

// File: rtl/circ_reg_stack.sv
module circ_reg_stack
    import stk_pkg::*;
#(
    parameter int WIDTH = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [WIDTH-1:0]  push_data_i,
    input  logic              pop_i,
    output logic [WIDTH-1:0]  pop_data_o,
    input  logic [TOP_W-1:0]  rel_idx_i,
    input  logic              rel_we_i,
    input  logic [WIDTH-1:0]  rel_wdata_i,
    output logic [WIDTH-1:0]  rel_rdata_o,
    input  logic              busy_set_i,
    input  logic              busy_clr_i,
    input  logic              cc_we_i,
    input  logic [3:0]        cc_i,
    output logic [STAT_W-1:0] status_o
);
    logic [TOP_W-1:0] top_q;
    logic             pop_go, relw_go, wr_en;
    logic [TOP_W-1:0] push_addr, rel_addr, wr_addr;
    logic [WIDTH-1:0] wr_data;

    // push outranks both the pop and the top-relative write
    always_comb begin
        pop_go    = pop_i && !push_i;
        relw_go   = rel_we_i && !push_i;
        push_addr = top_q - TOP_W'(1);
        rel_addr  = top_q + rel_idx_i;
        wr_en     = push_i || relw_go;
        wr_addr   = push_i ? push_addr : rel_addr;
        wr_data   = push_i ? push_data_i : rel_wdata_i;
    end

    stk_ptr i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_i),
        .pop_en   (pop_go),
        .busy_set (busy_set_i),
        .busy_clr (busy_clr_i),
        .cc_we    (cc_we_i),
        .cc_in    (cc_i),
        .top_o    (top_q),
        .status_o (status_o)
    );

    stk_array #(.WIDTH(WIDTH)) i_arr (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (top_q),
        .rdata_a (pop_data_o),
        .raddr_b (rel_addr),
        .rdata_b (rel_rdata_o)
    );

    p_push_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> pop_data_o == $past(push_data_i));
    p_relw_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_we_i && !push_i && !pop_i) |=> rel_rdata_o == $past(rel_wdata_i) || rel_idx_i != $past(rel_idx_i));
    p_status_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> status_o[13:11] == $past(status_o[13:11]) - TOP_W'(1));
endmodule

// File: tb/test_circ_reg_stack.sv
`timescale 1ns/1ps
module test_circ_reg_stack;
    localparam int W = 80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 0, pop_i = 0, rel_we_i = 0;
    logic [W-1:0] push_data_i = '0, rel_wdata_i = '0;
    logic [2:0]   rel_idx_i = '0;
    logic         busy_set_i = 0, busy_clr_i = 0, cc_we_i = 0;
    logic [3:0]   cc_i = '0;
    logic [W-1:0] pop_data_o, rel_rdata_o;
    logic [15:0]  status_o;

    int vecs = 0, errs = 0;
    logic [W-1:0] mdl [8];
    logic [2:0]   mtop = 0;
    logic         mbusy = 0;
    logic [3:0]   mcc = 0;

    always #10 clk = ~clk;

    circ_reg_stack i_circ_reg_stack (.*);

    function automatic logic [W-1:0] pat(input int k);
        return {16'(k * 13 + 1), 32'(k * 32'h9E3779B9), 32'(~k)};
    endfunction

    function automatic logic [15:0] exp_status();
        return {mbusy, mcc[3], mtop, mcc[2:0], 8'h00};
    endfunction

    task automatic check(input string req, input string ctx, input logic [W-1:0] act, input logic [W-1:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s (%s): actual %h expected %h", req, ctx, act, exp);
        end
    endtask

    task automatic run(input logic psh, input logic [W-1:0] pd, input logic pp,
                       input logic [2:0] ri, input logic rw, input logic [W-1:0] rwd,
                       input logic bs, input logic bc, input logic cw, input logic [3:0] cv,
                       input string ctx);
        logic [2:0] ra;
        push_i = psh; push_data_i = pd; pop_i = pp; rel_idx_i = ri;
        rel_we_i = rw; rel_wdata_i = rwd; busy_set_i = bs; busy_clr_i = bc;
        cc_we_i = cw; cc_i = cv;
        #1;
        check("R3", ctx, pop_data_o, mdl[mtop]);
        ra = mtop + ri;
        check("R4", ctx, rel_rdata_o, mdl[ra]);
        check("R8", ctx, W'(status_o), W'(exp_status()));
        @(posedge clk);
        if (psh) begin
            mtop = mtop - 3'd1;
            mdl[mtop] = pd;
        end else begin
            if (rw) mdl[ra] = rwd;
            if (pp) mtop = mtop + 3'd1;
        end
        if (bs) mbusy = 1'b1; else if (bc) mbusy = 1'b0;
        if (cw) mcc = cv;
        @(negedge clk);
        push_i = 0; pop_i = 0; rel_we_i = 0; busy_set_i = 0; busy_clr_i = 0; cc_we_i = 0;
    endtask

    task automatic read_all(input string ctx);
        for (int i = 0; i < 8; i++)
            run(0, '0, 0, 3'(i), 0, '0, 0, 0, 0, 4'h0, ctx);
    endtask

    initial begin
        #(20 * 100000);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 'x;
        #35;
        check("R1", "in reset", W'(status_o), W'(16'h0000));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "after reset", W'(status_o), W'(16'h0000));
        @(negedge clk);

        // R2 / R11: ten pushes, pointer wraps from 0 to 7
        for (int k = 0; k < 10; k++)
            run(1, pat(k), 0, 0, 0, '0, 0, 0, 0, 4'h0, "R2 R11 push");
        check("R11", "top after 10 pushes", W'(status_o[13:11]), W'(3'd6));

        // R4 / R3: all ST(i) at each of eight pointer positions, then pop
        for (int p = 0; p < 8; p++) begin
            read_all("R4 sweep");
            run(0, '0, 1, 0, 0, '0, 0, 0, 0, 4'h0, "R3 R11 pop");
        end

        // R5: ST(i) writes at every distance, then read back
        for (int i = 0; i < 8; i++)
            run(0, '0, 0, 3'(i), 1, pat(100 + i), 0, 0, 0, 4'h0, "R5 write");
        read_all("R5 readback");
        run(0, '0, 1, 3'd2, 1, pat(200), 0, 0, 0, 4'h0, "R5 write with pop");
        read_all("R5 readback after pop");

        // R6: push with concurrent ST(i) write
        run(1, pat(300), 0, 3'd3, 1, pat(301), 0, 0, 0, 4'h0, "R6 push+write");
        read_all("R6 readback");

        // R7: push with concurrent pop
        run(1, pat(400), 1, 0, 0, '0, 0, 0, 0, 4'h0, "R7 push+pop");
        read_all("R7 readback");

        // R9: busy set/clear combinations while stack commands run
        run(0, '0, 0, 0, 0, '0, 1, 0, 0, 4'h0, "R9 set");
        run(1, pat(500), 0, 0, 0, '0, 0, 0, 0, 4'h0, "R9 push while busy");
        run(0, '0, 1, 0, 0, '0, 0, 1, 0, 4'h0, "R9 clear with pop");
        run(0, '0, 0, 0, 0, '0, 1, 1, 0, 4'h0, "R9 set and clear");
        run(0, '0, 0, 0, 0, '0, 0, 1, 0, 4'h0, "R9 clear");
        check("R9", "busy cleared", W'(status_o[15]), W'(1'b0));

        // R10: all condition-code values, then hold with write enable low
        for (int v = 0; v < 16; v++)
            run(0, '0, 0, 0, 0, '0, 0, 0, 1, 4'(v), "R10 load");
        run(0, '0, 0, 0, 0, '0, 0, 0, 0, 4'h0, "R10 hold");
        run(0, '0, 0, 0, 0, '0, 0, 0, 0, 4'h5, "R10 hold");
        check("R10", "codes held", W'({status_o[14], status_o[10:8]}), W'(4'hF));

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule